// File: doc/BRIEF.md
# Four-Phase Return-to-Zero Handshake Link

This block moves one data word at a time between two clock domains that have no fixed relationship. A requester controller and a provider controller talk only through a request level and an acknowledge level. Every transfer runs a full return-to-zero cycle: request rises, acknowledge rises with the data held steady, request falls, and then acknowledge falls.

On the requester side, local logic pulses `start`. The controller raises request and stays `busy` until the whole cycle has finished. When the acknowledge arrives, the controller captures the word and pulses `rd_valid` for one cycle. On the provider side, `pending` tells local logic that a request is waiting. Local logic answers with a one-cycle `done` and the word on `wr_data`. The provider then raises acknowledge and holds the word until it sees request fall.

Each side brings in the other side's level through two cascaded flops. One further register follows them, and its output is the only copy that the rest of that side's logic uses. Each side has its own asynchronous active-low reset.

Top module: `hs4_link`

## Requirements
- R1: While a side is in reset, its outputs are low: `busy` and `rd_valid` on the requester side, `pending` on the provider side.
- R2: A `start` pulse in idle makes `busy` read 1 at the requester clock edge that samples it, and request rises at that edge.
- R3: After request has crossed into the provider domain, `pending` rises. A `done` sampled while `pending` is 1 clears `pending` and raises acknowledge at the next provider edge.
- R4: The requester emits exactly one `rd_valid` pulse, one requester cycle long, per transfer. `rd_data` carries, during that pulse and afterwards, the `wr_data` value that was sampled with `done`.
- R5: A `start` that arrives while `busy` is 1 has no effect, including during the wait for acknowledge to return low. No second transfer follows it.
- R6: A `done` that arrives while `pending` is 0 has no effect. The next transfer delivers only the word given with the `done` that answered it.
- R7: `busy` stays 1 after the `rd_valid` pulse until the requester has seen acknowledge low. It then returns to 0.
- R8: The handshake follows the four-phase order. Acknowledge rises only while the provider sees request high. Request falls only while the requester sees acknowledge high. The provider's data register is stable for as long as acknowledge is high. A change on `wr_data` after `done` does not reach `rd_data`.
- R9: A provider reset in mid-transfer drops `pending` and acknowledge. After release the provider sees the still-raised request again, and the transfer completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_clk | input | 1 | Requester-side clock |
| req_rst_n | input | 1 | Requester-side asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that asks for a transfer |
| busy | output | 1 | Requester is in a transfer or waiting for acknowledge low |
| rd_data | output | DATA_W | Word captured from the provider |
| rd_valid | output | 1 | One-cycle strobe that marks a new `rd_data` |
| prv_clk | input | 1 | Provider-side clock |
| prv_rst_n | input | 1 | Provider-side asynchronous reset, active low |
| pending | output | 1 | A request waits for service by local logic |
| done | input | 1 | One-cycle pulse from local logic that supplies the word |
| wr_data | input | DATA_W | Word delivered with `done` |

## Verification
The assertions take each input to be a clean level sampled in its own domain, with `start` and `done` pulses one cycle long. They also assume that the provider's data register does not change while the requester could be sampling it; the provider's own data-hold check covers that assumption. The stimulus changes every input at the falling edge of the clock that owns it. It runs transfers at several provider-to-requester period ratios, from faster than the requester to several times slower. It places stray `start` and `done` pulses only in the phases where they must be ignored.

// File: rtl/hs4_link.sv
`timescale 1ns/1ps
module hs4_link #(
  parameter int DATA_W = 16
) (
  input  logic              req_clk,
  input  logic              req_rst_n,
  input  logic              start,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              prv_clk,
  input  logic              prv_rst_n,
  output logic              pending,
  input  logic              done,
  input  logic [DATA_W-1:0] wr_data
);

  typedef enum logic [1:0] {R_IDLE, R_WAIT_HI, R_WAIT_LO} rst_t;
  typedef enum logic [1:0] {P_IDLE, P_SERVE, P_ACKED} pst_t;

  rst_t              r_st;
  pst_t              p_st;
  logic              req_q, ack_q;
  logic [1:0]        ack_sync, req_sync;
  logic              ack_seen, req_seen;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge req_clk or negedge req_rst_n)
    if (!req_rst_n) begin
      ack_sync <= '0;
      ack_seen <= 1'b0;
    end else begin
      ack_sync <= {ack_sync[0], ack_q};
      ack_seen <= ack_sync[1];
    end

  always_ff @(posedge req_clk or negedge req_rst_n)
    if (!req_rst_n) begin
      r_st     <= R_IDLE;
      req_q    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (r_st)
        R_IDLE: if (start) begin
          req_q <= 1'b1;
          r_st  <= R_WAIT_HI;
        end
        R_WAIT_HI: if (ack_seen) begin
          rd_data  <= data_q;
          rd_valid <= 1'b1;
          req_q    <= 1'b0;
          r_st     <= R_WAIT_LO;
        end
        R_WAIT_LO: if (!ack_seen) r_st <= R_IDLE;
        default: r_st <= R_IDLE;
      endcase
    end

  assign busy = (r_st != R_IDLE);

  always_ff @(posedge prv_clk or negedge prv_rst_n)
    if (!prv_rst_n) begin
      req_sync <= '0;
      req_seen <= 1'b0;
    end else begin
      req_sync <= {req_sync[0], req_q};
      req_seen <= req_sync[1];
    end

  always_ff @(posedge prv_clk or negedge prv_rst_n)
    if (!prv_rst_n) begin
      p_st   <= P_IDLE;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      case (p_st)
        P_IDLE: if (req_seen) p_st <= P_SERVE;
        P_SERVE: if (done) begin
          data_q <= wr_data;
          ack_q  <= 1'b1;
          p_st   <= P_ACKED;
        end
        P_ACKED: if (!req_seen) begin
          ack_q <= 1'b0;
          p_st  <= P_IDLE;
        end
        default: p_st <= P_IDLE;
      endcase
    end

  assign pending = (p_st == P_SERVE);

endmodule

// File: rtl/hs4_link_chk.sv
`timescale 1ns/1ps
module hs4_link_chk #(
  parameter int DATA_W = 16
) (
  input logic              req_clk,
  input logic              req_rst_n,
  input logic              prv_clk,
  input logic              prv_rst_n,
  input logic              req_q,
  input logic              ack_q,
  input logic              req_seen,
  input logic              ack_seen,
  input logic              rd_valid,
  input logic              pending,
  input logic              done,
  input logic [DATA_W-1:0] data_q
);

  // R4
  valid_pulse_chk: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    rd_valid |=> !rd_valid);

  // R5
  req_rise_chk: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    $rose(req_q) |-> !ack_seen);

  // R8
  req_fall_chk: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    $fell(req_q) |-> ack_seen);

  // R8
  ack_rise_chk: assert property (@(posedge prv_clk) disable iff (!prv_rst_n)
    $rose(ack_q) |-> req_seen);

  // R8
  data_hold_chk: assert property (@(posedge prv_clk) disable iff (!prv_rst_n)
    ack_q |=> (!ack_q || $stable(data_q)));

  // R3
  done_ack_chk: assert property (@(posedge prv_clk) disable iff (!prv_rst_n)
    (pending && done) |=> (ack_q && !pending));

endmodule

bind hs4_link hs4_link_chk #(.DATA_W(DATA_W)) chk_i (
  .req_clk  (req_clk),
  .req_rst_n(req_rst_n),
  .prv_clk  (prv_clk),
  .prv_rst_n(prv_rst_n),
  .req_q    (req_q),
  .ack_q    (ack_q),
  .req_seen (req_seen),
  .ack_seen (ack_seen),
  .rd_valid (rd_valid),
  .pending  (pending),
  .done     (done),
  .data_q   (data_q)
);

// File: tb/hs4_link_tb_top.sv
`timescale 1ns/1ps
module hs4_link_tb_top;
  localparam int W = 16;
  localparam int LIMIT = 400;

  logic req_clk = 1'b0, prv_clk = 1'b0;
  logic req_rst_n = 1'b0, prv_rst_n = 1'b0;
  logic start = 1'b0, done = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic busy, rd_valid, pending;
  logic [W-1:0] rd_data;
  int prv_half = 5;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 req_clk = ~req_clk;
  always #(prv_half) prv_clk = ~prv_clk;

  hs4_link #(.DATA_W(W)) dut_i (
    .req_clk(req_clk), .req_rst_n(req_rst_n), .start(start), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .prv_clk(prv_clk),
    .prv_rst_n(prv_rst_n), .pending(pending), .done(done), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pending(input string req);
    int n = 0;
    @(negedge prv_clk);
    while (!pending && n < LIMIT) begin
      @(negedge prv_clk);
      n++;
    end
    check(pending == 1'b1, req, pending, 1);
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    @(negedge req_clk);
    while (!rd_valid && n < LIMIT) begin
      @(negedge req_clk);
      n++;
    end
    check(rd_valid == 1'b1, req, rd_valid, 1);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < LIMIT) begin
      @(negedge req_clk);
      n++;
    end
    check(busy == 1'b0, req, busy, 0);
  endtask

  task automatic pulse_done(input logic [W-1:0] d);
    @(negedge prv_clk);
    done = 1'b1;
    wr_data = d;
    @(negedge prv_clk);
    done = 1'b0;
    check(pending == 1'b0, "R3 pending cleared by done", pending, 0);
    wr_data = ~d;
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
    check(pending == 1'b0, "R1 pending in reset", pending, 0);
    #23;
    req_rst_n = 1'b1;
    prv_rst_n = 1'b1;
    repeat (3) @(negedge req_clk);
  endtask

  task automatic t_xfer(input int half, input logic [W-1:0] d, input bit extra_start);
    prv_half = half;
    repeat (2) @(negedge prv_clk);
    @(negedge req_clk);
    start = 1'b1;
    @(negedge req_clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    wait_pending("R3 pending after request");
    pulse_done(d);
    wait_valid("R4 rd_valid strobe");
    check(rd_data == d, "R4/R8 rd_data", rd_data, d);
    @(negedge req_clk);
    check(rd_valid == 1'b0, "R4 strobe width", rd_valid, 0);
    check(busy == 1'b1, "R7 busy held after strobe", busy, 1);
    if (extra_start) begin
      start = 1'b1;
      @(negedge req_clk);
      start = 1'b0;
    end
    wait_idle("R7 busy drops after ack low");
    check(rd_data == d, "R4 rd_data kept", rd_data, d);
  endtask

  task automatic t_ignore_start();
    bit seen = 0;
    @(negedge req_clk);
    start = 1'b1;
    @(negedge req_clk);
    start = 1'b0;
    repeat (4) @(negedge req_clk);
    start = 1'b1;
    @(negedge req_clk);
    start = 1'b0;
    wait_pending("R5 first request");
    pulse_done(16'h0F0F);
    wait_valid("R5 strobe");
    @(negedge req_clk);
    start = 1'b1;
    @(negedge req_clk);
    start = 1'b0;
    wait_idle("R5 idle");
    for (int i = 0; i < 60; i++) begin
      @(negedge prv_clk);
      if (pending) seen = 1;
    end
    check(seen == 0, "R5 no second transfer", seen, 0);
    check(busy == 1'b0, "R5 still idle", busy, 0);
  endtask

  task automatic t_ignore_done();
    pulse_done_idle(16'hDEAD);
    check(pending == 1'b0, "R6 pending stays low", pending, 0);
    repeat (10) @(negedge req_clk);
    check(busy == 1'b0 && rd_valid == 1'b0, "R6 no activity", busy, 0);
    t_xfer(5, 16'h1234, 0);
    check(rd_data == 16'h1234, "R6 stray word not delivered", rd_data, 16'h1234);
  endtask

  task automatic pulse_done_idle(input logic [W-1:0] d);
    @(negedge prv_clk);
    done = 1'b1;
    wr_data = d;
    @(negedge prv_clk);
    done = 1'b0;
  endtask

  task automatic t_prv_reset();
    prv_half = 7;
    @(negedge req_clk);
    start = 1'b1;
    @(negedge req_clk);
    start = 1'b0;
    wait_pending("R9 pending before reset");
    prv_rst_n = 1'b0;
    @(negedge prv_clk);
    check(pending == 1'b0, "R9 pending in provider reset", pending, 0);
    check(busy == 1'b1, "R9 requester still busy", busy, 1);
    @(negedge prv_clk);
    prv_rst_n = 1'b1;
    wait_pending("R9 pending after release");
    pulse_done(16'hBEEF);
    wait_valid("R9 strobe after recovery");
    check(rd_data == 16'hBEEF, "R9 data after recovery", rd_data, 16'hBEEF);
    @(negedge req_clk);
    wait_idle("R9 idle after recovery");
  endtask

  initial begin
    t_reset();
    t_xfer(5, 16'hA5C3, 0);
    t_xfer(3, 16'h0001, 0);
    t_xfer(17, 16'hFFFE, 1);
    t_xfer(2, 16'h8000, 0);
    t_xfer(41, 16'h5A5A, 0);
    t_ignore_start();
    t_ignore_done();
    t_prv_reset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule